// File: doc/BRIEF.md
# Timestamp Memory Drain Controller

This controller lets host software empty one of two timestamp memories (receive or transmit) through three 32-bit registers. The host and the hardware take turns on a flag register: the host asks for a record, the hardware reads one 64-bit entry from the chosen memory and loads it into a pair of data registers, then marks the flag so the host knows the data is ready. The host reads both halves and asks again. When no records are left, the flag moves to a terminal state.

The memories are circular logs kept by separate logging hardware. That hardware reports its current write pointer and whether it has wrapped. At the first request the controller captures these values. It then walks from the oldest entry to the newest and drives the memory read port itself. Each memory has a read latency of one clock.

Top module: `ts_drain_ctrl`

## Requirements
- R1: After reset the flag reads IDLE (0), both data registers read 0, and neither memory read enable is asserted.
- R2: Register offsets are fixed. Offset 0 is the flag in bits [1:0], with IDLE=0, READ=1, READ_RAM=2 and FINISHED=3. Offset 1 holds bits [63:32] of the record, offset 2 holds bits [31:0], and offset 3 reads 0.
- R3: A write of the value 1 to offset 0 while the flag is IDLE or READ_RAM sets the flag to READ at the next clock. Each such request produces at most one read-enable pulse.
- R4: The data registers are loaded from the memory output one clock after the read enable pulses. The flag becomes READ_RAM on that same edge and never earlier.
- R5: The first record read is at address 0 if the memory has not wrapped, or at the captured write pointer if it has. Each later record is at the next address, wrapping from DEPTH-1 to 0. The number of records is the write pointer when not wrapped, or DEPTH when wrapped.
- R6: The direction input, sampled at the request made from IDLE, selects the transmit memory (1) or the receive memory (0). Only that memory's read enable ever pulses during the drain.
- R7: A request made after the last record has been delivered, or made while the selected memory is empty, moves the flag to FINISHED without any memory read.
- R8: FINISHED is kept until reset. Further requests leave the flag and both data registers unchanged.
- R9: The following writes have no effect on the flag or the data registers: a flag write of any value other than 1, a write to offsets 1 to 3, and a request made while the flag shows READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational from host_addr) |
| drain_tx | input | 1 | Memory select: 1 transmit, 0 receive |
| rx_wr_ptr | input | AW | Next write address of the receive memory |
| rx_wrapped | input | 1 | Receive memory has wrapped at least once |
| tx_wr_ptr | input | AW | Next write address of the transmit memory |
| tx_wrapped | input | 1 | Transmit memory has wrapped at least once |
| rx_rd_en | output | 1 | Receive memory read enable |
| tx_rd_en | output | 1 | Transmit memory read enable |
| rd_addr | output | AW | Shared memory read address |
| rx_rd_data | input | 64 | Receive memory read data, valid one clock after rx_rd_en |
| tx_rd_data | input | 64 | Transmit memory read data, valid one clock after tx_rd_en |

## Verification
The assertions assume three things about the inputs. The write pointers always lie below DEPTH. Each memory returns its data exactly one clock after its enable. The host touches the registers only through the strobe. The bench meets these assumptions with a memory model whose contents are a pure function of the direction and the address, and with pointers swept only over legal values. The other memory is given a different pointer on purpose, so that a drain that reads the wrong memory would show up.

// File: rtl/ts_drain_ctrl.sv
module ts_drain_ctrl #(
  parameter int DEPTH = 24576,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [1:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          drain_tx,
  input  logic [AW-1:0] rx_wr_ptr,
  input  logic          rx_wrapped,
  input  logic [AW-1:0] tx_wr_ptr,
  input  logic          tx_wrapped,
  output logic          rx_rd_en,
  output logic          tx_rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [63:0]   rx_rd_data,
  input  logic [63:0]   tx_rd_data
);
  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_REQ  = 2'd1;
  localparam logic [1:0] ST_RDY  = 2'd2;
  localparam logic [1:0] ST_DONE = 2'd3;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0]    flag;
  logic          sel_tx, busy;
  logic [AW-1:0] ptr;
  logic [CW-1:0] left;
  logic [31:0]   data_hi, data_lo;

  wire req_wr = host_wr && host_addr == 2'd0 && host_wdata == 32'd1 &&
                (flag == ST_IDLE || flag == ST_RDY);
  wire start = req_wr && flag == ST_IDLE;
  wire [AW-1:0] cur_ptr = drain_tx ? tx_wr_ptr : rx_wr_ptr;
  wire          cur_wrap = drain_tx ? tx_wrapped : rx_wrapped;
  wire fetch = flag == ST_REQ && !busy && left != '0;

  assign rx_rd_en = fetch && !sel_tx;
  assign tx_rd_en = fetch && sel_tx;
  assign rd_addr  = ptr;

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = {30'd0, flag};
      2'd1:    host_rdata = data_hi;
      2'd2:    host_rdata = data_lo;
      default: host_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= ST_IDLE;
      sel_tx  <= 1'b0;
      busy    <= 1'b0;
      ptr     <= '0;
      left    <= '0;
      data_hi <= '0;
      data_lo <= '0;
    end else begin
      if (start) begin
        sel_tx <= drain_tx;
        ptr    <= cur_wrap ? cur_ptr : '0;
        left   <= cur_wrap ? CW'(DEPTH) : {1'b0, cur_ptr};
      end
      if (req_wr)
        flag <= ST_REQ;
      else if (flag == ST_REQ && !busy && left == '0)
        flag <= ST_DONE;
      if (fetch) begin
        busy <= 1'b1;
        ptr  <= (ptr == LAST) ? '0 : ptr + 1'b1;
        left <= left - 1'b1;
      end
      if (busy) begin
        busy <= 1'b0;
        {data_hi, data_lo} <= sel_tx ? tx_rd_data : rx_rd_data;
        flag <= ST_RDY;
      end
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (flag == ST_IDLE && !rx_rd_en && !tx_rd_en));
  a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_rd_en, tx_rd_en}));
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_en || tx_rd_en) |=> !(rx_rd_en || tx_rd_en));
  a_r4_ready_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_en || tx_rd_en) |=> ##1 (flag == ST_RDY));
  a_r4_ready_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag == ST_RDY) |-> $past(rx_rd_en || tx_rd_en, 2));
  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_en || tx_rd_en) |-> (rd_addr <= LAST));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == ST_DONE) |=> (flag == ST_DONE && $stable(data_hi) && $stable(data_lo)));
endmodule

// File: tb/ts_drain_ctrl_tb.sv
module ts_drain_ctrl_tb;
  localparam int DEPTH = 6;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic drain_tx = 1'b0;
  logic [AW-1:0] rx_wr_ptr = '0, tx_wr_ptr = '0;
  logic rx_wrapped = 1'b0, tx_wrapped = 1'b0;
  logic rx_rd_en, tx_rd_en;
  logic [AW-1:0] rd_addr;
  logic [63:0] rx_q, tx_q;
  int rx_pulses, tx_pulses;
  int errors = 0, checks = 0, cycles = 0;
  bit finished_run = 1'b0;

  always #5 clk = ~clk;

  ts_drain_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .drain_tx(drain_tx),
    .rx_wr_ptr(rx_wr_ptr), .rx_wrapped(rx_wrapped), .tx_wr_ptr(tx_wr_ptr),
    .tx_wrapped(tx_wrapped), .rx_rd_en(rx_rd_en), .tx_rd_en(tx_rd_en),
    .rd_addr(rd_addr), .rx_rd_data(rx_q), .tx_rd_data(tx_q));

  function automatic logic [63:0] pat(input bit dir, input int addr);
    logic [31:0] h, l;
    h = {16'hBEEF, 7'd0, dir, 8'(addr)};
    l = 32'h1234_0000 + 32'(addr * 3) + (dir ? 32'd100 : 32'd0);
    return {h, l};
  endfunction

  always_ff @(posedge clk) begin
    rx_q <= pat(1'b0, int'(rd_addr)) ^ (rx_rd_en ? 64'd0 : 64'hFFFF_FFFF_FFFF_FFFF);
    tx_q <= pat(1'b1, int'(rd_addr)) ^ (tx_rd_en ? 64'd0 : 64'hFFFF_FFFF_FFFF_FFFF);
    if (!rst_n) begin
      rx_pulses <= 0;
      tx_pulses <= 0;
    end else begin
      if (rx_rd_en) rx_pulses <= rx_pulses + 1;
      if (tx_rd_en) tx_pulses <= tx_pulses + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 2'd0;
  endtask

  task automatic wait_flag(output logic [31:0] v);
    for (int k = 0; k < 8; k++) begin
      rd(2'd0, v);
      if (v != 32'd1) break;
      @(negedge clk);
    end
  endtask

  task automatic drain(input bit dir, input bit wrp, input int wp);
    int n, start, other;
    logic [31:0] v, h, l;
    logic [63:0] e;
    n = wrp ? DEPTH : wp;
    start = wrp ? wp : 0;
    other = (wp + 1) % DEPTH;
    @(negedge clk);
    rst_n = 1'b0;
    drain_tx = dir;
    rx_wr_ptr = AW'(dir ? other : wp); rx_wrapped = dir ? 1'b0 : wrp;
    tx_wr_ptr = AW'(dir ? wp : other); tx_wrapped = dir ? wrp : 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 flag after reset", 64'(v), 64'd0);
    rd(2'd1, h); rd(2'd2, l); check("R1 data after reset", {h, l}, 64'd0);
    rd(2'd3, v); check("R2 offset 3 reads zero", 64'(v), 64'd0);
    wr(2'd0, 32'd2);
    rd(2'd0, v); check("R9 non-request value ignored in IDLE", 64'(v), 64'd0);
    e = 64'd0;
    for (int i = 0; i <= n; i++) begin
      wr(2'd0, 32'd1);
      rd(2'd0, v); check("R3 flag READ after request", 64'(v), 64'd1);
      if (i == 0) begin
        drain_tx = ~dir;
        wr(2'd0, 32'd1);
      end
      wait_flag(v);
      if (i < n) begin
        check("R4 flag READ_RAM", 64'(v), 64'd2);
        rd(2'd1, h); rd(2'd2, l);
        e = pat(dir, (start + i) % DEPTH);
        check("R5 record order and R4 data", {h, l}, e);
        check("R3 one read per request", 64'(dir ? tx_pulses : rx_pulses), 64'(i + 1));
        if (i == 0) begin
          wr(2'd0, 32'd3);
          wr(2'd1, 32'h5555_5555);
          wr(2'd3, 32'd1);
          rd(2'd0, v); check("R9 ignored writes keep flag", 64'(v), 64'd2);
          rd(2'd1, h); rd(2'd2, l);
          check("R9 ignored writes keep data", {h, l}, e);
        end
      end else begin
        check("R7 finished after last", 64'(v), 64'd3);
        check("R7 no extra read", 64'(dir ? tx_pulses : rx_pulses), 64'(n));
      end
    end
    check("R6 other memory untouched", 64'(dir ? rx_pulses : tx_pulses), 64'd0);
    wr(2'd0, 32'd1);
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R8 finished sticky", 64'(v), 64'd3);
    rd(2'd1, h); rd(2'd2, l); check("R8 data unchanged", {h, l}, e);
  endtask

  initial begin
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < DEPTH; p++)
          drain(d[0], w[0], p);
    finished_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule